// File: doc/BRIEF.md
# Cascaded Multi-Modulus Cycle-Swallow Divider

This block divides a fast input clock by a programmable ratio between 64 and 127. The first element is a front stage. It has a two-bit ring of divide-by-2 flops, which gives four phases spaced one input cycle apart. The front stage divides by 4 nominally. When the control word asks for it, the front stage holds its ring for up to three input cycles. This moves the selected output phase later, so the front stage divides by 4, 5, 6 or 7. A chain of divide-by-2/3 cells follows the front stage. Each cell halves its input tick rate. A cell whose control bit is set consumes one extra input tick once per output period. Because of the cell's position in the chain, that one tick is worth 4, 8, 16 or 32 input cycles.

A modulus-control signal starts at the last cell and travels back toward the front stage. It is asserted only in the cycle where every stage ends its own period together, which is the output-period boundary. At that instant each stage loads its swallow setting from the live control word. This means the whole word is sampled once per output period. A change made at any other time takes effect at the next boundary. The divided clock goes high at each boundary. It goes low at the first input tick that the last cell receives after the boundary.

The block is used in a fractional-N synthesizer. There, the control word is updated every reference period.

Top module: `mmd_divider`

## Requirements
- R1: While reset is held, div_out is 1. The first output period after reset release lasts exactly 64 input cycles, whatever mod_word holds. The rising edge of div_out comes 64 rising clk edges after reset release.
- R2: Every output period, measured from one rising edge of div_out to the next, lasts 64 + mod_word input cycles. Here mod_word is the value present at the clk edge that started the period. All codes 0 to 63 give 64 to 127 cycles.
- R3: The two low bits mod_word[1:0] act on the front stage. They add 0, 1, 2 or 3 input cycles to the period.
- R4: Bits mod_word[2], [3], [4] and [5] add 4, 8, 16 and 32 input cycles respectively.
- R5: A change of mod_word that is not at a period boundary has no effect on the current period. It only sets the length of the following period.
- R6: Each 2/3 cell swallows at most one input tick per output period. It loads its swallow request only when the modulus-control signal reaches it at the boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-rate input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_word | input | 6 | Ratio control; period = 64 + mod_word input cycles |
| div_out | output | 1 | Divided clock, rising at each period boundary |

## Verification
The assertions take two things for granted. First, reset is released away from a clk edge. Second, mod_word only needs to be valid at boundary edges; it may change in any other cycle without harm. The bench changes mod_word a fraction of a period after an input edge, never on one. It changes the word shortly after each observed rising edge of div_out. It also changes the word deliberately in the middle of some periods, so the single sampling point is exercised. Every code from 0 to 63 is applied in turn, followed by seeded random codes with random mid-period changes.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
  // width of the front-stage phase ring (two divide-by-2 flops)
  localparam int FRONT_W = 2;

  // nominal division ratio of the whole chain for a control width
  function automatic int base_ratio(input int ctrl_w);
    return 1 << ctrl_w;
  endfunction
endpackage

// File: rtl/mmd_front.sv
module mmd_front #(
  parameter int RING_W = mmd_pkg::FRONT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RING_W-1:0] swal_bits,
  input  logic              mod_in,
  output logic              tick_o
);
  localparam int GAP_W = RING_W + 1;
  localparam int NOM   = 1 << RING_W;

  logic [RING_W-1:0] ring;
  logic [RING_W-1:0] hold;
  logic              advance;

  // each held cycle shifts the selected phase one input cycle later
  assign advance = (hold == '0);
  assign tick_o  = advance && (ring == {RING_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring <= '0;
      hold <= '0;
    end else begin
      if (advance) ring <= ring + 1'b1;
      else         hold <= hold - 1'b1;
      if (tick_o && mod_in) hold <= swal_bits;
    end
  end

  // gap counter for the period check
  logic [GAP_W-1:0] gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gap <= '0;
    else if (tick_o) gap <= '0;
    else             gap <= gap + 1'b1;
  end

  // R3: front period stays within NOM .. 2*NOM-1 input cycles
  p_front_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> (int'(gap) >= NOM - 1) && (int'(gap) <= 2*NOM - 2));

  // R3: a hold is only loaded when the modulus control arrives
  p_hold_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hold) == '0 && hold != '0) |-> $past(tick_o && mod_in));
endmodule

// File: rtl/mmd_cell.sv
module mmd_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_bit,
  input  logic tick_i,
  input  logic mod_i,
  output logic tick_o,
  output logic mod_o
);
  logic st;
  logic sw;

  // every second accepted input tick passes on; a pending swallow eats one
  assign tick_o = tick_i && !sw && st;
  assign mod_o  = mod_i && tick_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= 1'b0;
      sw <= 1'b0;
    end else begin
      if (tick_i) begin
        if (sw) sw <= 1'b0;
        else    st <= ~st;
      end
      if (tick_o && mod_i) sw <= ctrl_bit;
    end
  end

  // swallow counter for the once-per-period check
  logic [1:0] sw_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                sw_cnt <= '0;
    else if (tick_o && mod_i)  sw_cnt <= '0;
    else if (tick_i && sw && sw_cnt != 2'd3) sw_cnt <= sw_cnt + 1'b1;
  end

  // R6: at most one swallowed tick per output period
  p_one_swallow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_cnt <= 2'd1);

  // R6: a swallow request appears only after the boundary handshake
  p_sw_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw) |-> $past(mod_i && tick_o));
endmodule

// File: rtl/mmd_divider.sv
module mmd_divider #(
  parameter int CTRL_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] mod_word,
  output logic              div_out
);
  localparam int FW      = mmd_pkg::FRONT_W;
  localparam int N_CELLS = CTRL_W - FW;
  localparam int BASE    = mmd_pkg::base_ratio(CTRL_W);
  localparam int PER_W   = CTRL_W + 1;

  logic              tick [0:N_CELLS];
  logic [N_CELLS:0]  mi;
  logic              boundary;

  assign mi[N_CELLS] = 1'b1;

  mmd_front #(.RING_W(FW)) front_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .swal_bits(mod_word[FW-1:0]),
    .mod_in   (mi[0]),
    .tick_o   (tick[0])
  );

  for (genvar k = 1; k <= N_CELLS; k++) begin : g_cell
    mmd_cell cell_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl_bit(mod_word[k+FW-1]),
      .tick_i  (tick[k-1]),
      .mod_i   (mi[k]),
      .tick_o  (tick[k]),
      .mod_o   (mi[k-1])
    );
  end

  assign boundary = tick[N_CELLS];

  logic out_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                out_q <= 1'b1;
    else if (boundary)         out_q <= 1'b1;
    else if (tick[N_CELLS-1])  out_q <= 1'b0;
  end
  assign div_out = out_q;

  // period tracking for the ratio check
  logic [PER_W-1:0] per_cnt;
  logic [PER_W-1:0] exp_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_cnt <= '0;
      exp_q   <= PER_W'(BASE);
    end else if (boundary) begin
      per_cnt <= '0;
      exp_q   <= PER_W'(BASE) + PER_W'(mod_word);
    end else begin
      per_cnt <= per_cnt + 1'b1;
    end
  end

  // R2: each period equals the ratio sampled at its starting boundary
  p_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |-> (per_cnt == exp_q - 1'b1));

  // R1: output is high from a boundary until the last cell's first input
  p_out_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> div_out);
endmodule

// File: tb/mmd_divider_tb_top.sv
module mmd_divider_tb_top;
  localparam int CLK_T = 10;
  localparam int CW    = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] mod_word = 6'd45;
  logic          div_out;

  int total = 0;
  int bad = 0;
  int nrise = 0;
  int cyc = 0;
  int exp_p = 64;
  string exp_tag = "R1";
  string drv_tag = "R2";
  logic prev_out = 1'b1;
  logic done = 1'b0;

  always #(CLK_T/2) clk = ~clk;

  mmd_divider #(.CTRL_W(CW)) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .mod_word(mod_word),
    .div_out (div_out)
  );

  function automatic int ratio_of(input logic [CW-1:0] c);
    int r;
    r = 64 + int'(c[1:0]);
    if (c[2]) r += 4;
    if (c[3]) r += 8;
    if (c[4]) r += 16;
    if (c[5]) r += 32;
    return r;
  endfunction

  function automatic string tag_of(input logic [CW-1:0] c);
    if (c == 6'd63)                    return "R6";
    if (c[5:2] == 0 && c[1:0] != 0)    return "R3";
    if (c[1:0] == 0 && c[5:2] != 0)    return "R4";
    return "R2";
  endfunction

  // monitor, sampling away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0;
      prev_out = div_out;
      total++;
      if (div_out !== 1'b1) begin
        bad++;
        $display("FAIL R1 div_out in reset=%b expected=1", div_out);
      end
    end else begin
      cyc++;
      if (div_out === 1'b1 && prev_out === 1'b0) begin
        total++;
        if (cyc != exp_p) begin
          bad++;
          $display("FAIL %s period=%0d expected=%0d", exp_tag, cyc, exp_p);
        end
        exp_p = ratio_of(mod_word);
        exp_tag = drv_tag;
        cyc = 0;
        nrise++;
      end
      prev_out = div_out;
    end
  end

  task automatic after_rise();
    int seen;
    seen = nrise;
    wait (nrise != seen);
    #2;
  endtask

  task automatic set_code(input logic [CW-1:0] c, input string t);
    mod_word = c;
    drv_tag = t;
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed1);
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
    // R1: first period ignores the word present in reset
    after_rise();
    // R2 R3 R4 R6: every code in turn
    for (int c = 0; c < 64; c++) begin
      set_code(6'(c), tag_of(6'(c)));
      after_rise();
    end
    // R5: mid-period changes only affect the next period
    for (int i = 0; i < 12; i++) begin
      set_code(6'($urandom_range(0, 63)), "R5");
      after_rise();
      #(CLK_T * (5 + i * 4));
      set_code(6'($urandom_range(0, 63)), "R2");
      after_rise();
    end
    // R2: seeded random codes with occasional mid-period changes
    for (int i = 0; i < 120; i++) begin
      logic [CW-1:0] c;
      c = 6'($urandom_range(0, 63));
      set_code(c, tag_of(c));
      if ($urandom_range(0, 3) == 0) begin
        after_rise();
        #(CLK_T * $urandom_range(1, 60));
        c = 6'($urandom_range(0, 63));
        set_code(c, "R5");
      end
      after_rise();
    end
    after_rise();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule